// File: doc/BRIEF.md
# Indexed-Colour Frame Scanout

This block turns one frame of byte-per-pixel video memory into a stream of 24-bit RGB pixels. After a frame-start strobe it walks the frame in row-major order from address zero. For each pixel it reads an 8-bit colour index from a synchronous video-memory port. It passes that index to a synchronous palette port and presents the returned red, green and blue components on its pixel output. A valid/ready handshake carries the output, with end-of-line and end-of-frame tags.

Width, height and a force-blank control are sampled when a frame is accepted and held for the whole frame. In force-blank mode every pixel is black and the palette is never read. A strobe that arrives while either dimension is zero produces no frame. A per-frame flag tells the consumer whether the frame needs a full redraw: this is the case for the first frame after reset, and for any frame whose blank mode or dimensions differ from the last frame produced.

The controller has three named states. `SC_IDLE` waits for a strobe. On "accept" (strobe with both dimensions non-zero) it moves to `SC_SCAN`. A strobe with a zero dimension is a "reject" and leaves the controller in `SC_IDLE`. `SC_SCAN` issues one memory read per advancing cycle. On "last issue" (the read for the final pixel) it moves to `SC_DRAIN`. `SC_DRAIN` goes back to `SC_IDLE` once the two-stage read pipeline is empty ("drained").

Top module: `pal_scanout`

## Requirements
- R1: Pixel n of a frame (n = y*width + x) is the palette entry selected by the video-memory byte at address n, and the palette is read exactly once per pixel in graphics mode.
- R2: A palette word carries red in bits 23:16, green in bits 15:8 and blue in bits 7:0, and `pix_rgb` uses the same layout.
- R3: With `cfg_blank` high at frame accept, every pixel of that frame is 24'h000000 and `pal_rd_en` stays low for the whole frame.
- R4: A strobe with `cfg_width` or `cfg_height` equal to zero produces no memory read and no valid pixel, and leaves `frame_full` unchanged.
- R5: `pix_eol` is high exactly on pixels with x = width-1, and `pix_eof` is high only on the pixel with x = width-1 and y = height-1.
- R6: While `pix_valid` is high and `pix_ready` is low, `pix_valid`, `pix_rgb`, `pix_eol` and `pix_eof` hold their values into the next cycle.
- R7: At accept, `frame_full` becomes 1 for the first frame after reset, or if blank mode, width or height differs from the last accepted frame; otherwise it becomes 0. Rejected strobes do not count as frames.
- R8: Width, height and blank mode are taken only at accept. Changing them mid-frame has no effect on the frame in flight.
- R9: A strobe while a frame is in flight is ignored and does not change `frame_full`.
- R10: Each accepted frame delivers exactly width*height pixels and issues exactly width*height memory reads, after which `pix_valid` stays low.
- R11: During and right after reset, `pix_valid`, `mem_rd_en` and `pal_rd_en` are low and `frame_full` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame-start strobe |
| cfg_width | input | WIDTH_W | Frame width in pixels |
| cfg_height | input | HEIGHT_W | Frame height in lines |
| cfg_blank | input | 1 | Force-blank control |
| mem_rd_en | output | 1 | Video-memory read enable |
| mem_rd_addr | output | ADDR_W | Video-memory byte address |
| mem_rd_data | input | IDX_W | Index returned one cycle after a read |
| pal_rd_en | output | 1 | Palette read enable |
| pal_rd_idx | output | IDX_W | Palette entry index |
| pal_rd_data | input | 3*COMP_W | R,G,B word returned one cycle after a read |
| pix_ready | input | 1 | Downstream ready |
| pix_valid | output | 1 | Pixel valid |
| pix_rgb | output | 3*COMP_W | Pixel colour |
| pix_eol | output | 1 | Last pixel of a line |
| pix_eof | output | 1 | Last pixel of the frame |
| frame_full | output | 1 | Current frame needs a full redraw |

## Verification
A wrong column or row counter shows up as misplaced end-of-line or end-of-frame tags, usually within the first line of a frame. A wrong address counter shows up as wrong colours on the first affected pixel, since each memory byte maps to a distinct colour. A pipeline tag that drops or doubles during a stall changes the pixel count or breaks the hold rule on the very next cycle. A stale controller state shows up at the end of the frame as extra reads, missing pixels or a rejected next strobe. An error in the full-redraw tracker appears one cycle after the next accept.

// File: rtl/pal_scan_pkg.sv
package pal_scan_pkg;

    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_SCAN  = 2'd1,
        SC_DRAIN = 2'd2
    } scan_state_t;

    typedef struct packed {
        logic valid;
        logic eol;
        logic eof;
    } pix_tag_t;

endpackage

// File: rtl/pal_scan_ctrl.sv
module pal_scan_ctrl
    import pal_scan_pkg::*;
#(
    parameter int W_W    = 10,
    parameter int H_W    = 10,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [W_W-1:0]    cfg_width,
    input  logic [H_W-1:0]    cfg_height,
    input  logic              adv,
    input  logic              pipe_empty,
    output logic              start_ok,
    output logic              busy,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output pix_tag_t          iss
);

    localparam int PROD_W = W_W + H_W;

    scan_state_t       state_q, state_d;
    logic [W_W-1:0]    w_q, x_q;
    logic [H_W-1:0]    h_q, y_q;
    logic [ADDR_W-1:0] addr_q;
    logic              last_col, last_pix, dims_ok;
    logic [PROD_W-1:0] frame_px;

    assign dims_ok  = (cfg_width != '0) && (cfg_height != '0);
    assign last_col = (x_q == w_q - W_W'(1));
    assign last_pix = last_col && (y_q == h_q - H_W'(1));
    assign frame_px = PROD_W'(w_q) * PROD_W'(h_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SC_IDLE;
        else        state_q <= state_d;
    end

    // next state: accept / reject / last issue / drained
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_IDLE:  if (start_ok)          state_d = SC_SCAN;
            SC_SCAN:  if (adv && last_pix)   state_d = SC_DRAIN;
            SC_DRAIN: if (pipe_empty)        state_d = SC_IDLE;
            default:                         state_d = SC_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        start_ok    = 1'b0;
        busy        = 1'b1;
        mem_rd_en   = 1'b0;
        unique case (state_q)
            SC_IDLE: begin
                busy     = 1'b0;
                start_ok = frame_start && dims_ok;
            end
            SC_SCAN:  mem_rd_en = adv;
            SC_DRAIN: mem_rd_en = 1'b0;
            default:  busy      = 1'b0;
        endcase
        mem_rd_addr = addr_q;
        iss.valid   = mem_rd_en;
        iss.eol     = last_col;
        iss.eof     = last_pix;
    end

    // frame geometry and scan position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q    <= '0;
            h_q    <= '0;
            x_q    <= '0;
            y_q    <= '0;
            addr_q <= '0;
        end else if (start_ok) begin
            w_q    <= cfg_width;
            h_q    <= cfg_height;
            x_q    <= '0;
            y_q    <= '0;
            addr_q <= '0;
        end else if (mem_rd_en) begin
            addr_q <= addr_q + ADDR_W'(1);
            if (last_col) begin
                x_q <= '0;
                y_q <= y_q + H_W'(1);
            end else begin
                x_q <= x_q + W_W'(1);
            end
        end
    end

    // R4: no memory traffic while waiting for a frame
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SC_IDLE) |-> !mem_rd_en);

    // R10: the read address never reaches the frame size while scanning
    p_no_overissue_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SC_SCAN) |-> (PROD_W'(addr_q) < frame_px));

endmodule

// File: rtl/pal_scan_pipe.sv
module pal_scan_pipe
    import pal_scan_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  pix_tag_t            iss,
    input  logic [IDX_W-1:0]    mem_rd_data,
    input  logic                blank_q,
    input  logic                pix_ready,
    input  logic [3*COMP_W-1:0] pal_rd_data,
    output logic                adv,
    output logic                pipe_empty,
    output logic                pal_rd_en,
    output logic [IDX_W-1:0]    pal_rd_idx,
    output logic                pix_valid,
    output logic                pix_eol,
    output logic                pix_eof,
    output logic [3*COMP_W-1:0] pix_rgb
);

    localparam int NCOMP = 3;

    pix_tag_t s1_q, s2_q;

    assign adv        = !s2_q.valid || pix_ready;
    assign pipe_empty = !s1_q.valid && !s2_q.valid;
    assign pal_rd_en  = adv && s1_q.valid && !blank_q;
    assign pal_rd_idx = mem_rd_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else if (adv) begin
            s1_q <= iss;
            s2_q <= s1_q;
        end
    end

    assign pix_valid = s2_q.valid;
    assign pix_eol   = s2_q.valid && s2_q.eol;
    assign pix_eof   = s2_q.valid && s2_q.eof;

    for (genvar c = 0; c < NCOMP; c++) begin : g_comp
        assign pix_rgb[c*COMP_W +: COMP_W] =
            blank_q ? '0 : pal_rd_data[c*COMP_W +: COMP_W];
    end

    // R6: a stalled pixel holds
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_rgb)
                                       && $stable(pix_eol) && $stable(pix_eof)));

    // R5: the frame's last pixel also closes its line
    p_eof_has_eol_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_eof) |-> pix_eol);

endmodule

// File: rtl/pal_scan_track.sv
module pal_scan_track #(
    parameter int W_W = 10,
    parameter int H_W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_ok,
    input  logic [W_W-1:0] cfg_width,
    input  logic [H_W-1:0] cfg_height,
    input  logic           cfg_blank,
    output logic           blank_q,
    output logic           frame_full
);

    logic           first_q;
    logic [W_W-1:0] pw_q;
    logic [H_W-1:0] ph_q;
    logic           changed;

    assign changed = first_q || (cfg_blank != blank_q) ||
                     (cfg_width != pw_q) || (cfg_height != ph_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q    <= 1'b1;
            blank_q    <= 1'b0;
            pw_q       <= '0;
            ph_q       <= '0;
            frame_full <= 1'b0;
        end else if (start_ok) begin
            first_q    <= 1'b0;
            blank_q    <= cfg_blank;
            pw_q       <= cfg_width;
            ph_q       <= cfg_height;
            frame_full <= changed;
        end
    end

endmodule

// File: rtl/pal_scanout.sv
module pal_scanout
    import pal_scan_pkg::*;
#(
    parameter int WIDTH_W  = 10,
    parameter int HEIGHT_W = 10,
    parameter int ADDR_W   = 20,
    parameter int IDX_W    = 8,
    parameter int COMP_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic [WIDTH_W-1:0]  cfg_width,
    input  logic [HEIGHT_W-1:0] cfg_height,
    input  logic                cfg_blank,
    output logic                mem_rd_en,
    output logic [ADDR_W-1:0]   mem_rd_addr,
    input  logic [IDX_W-1:0]    mem_rd_data,
    output logic                pal_rd_en,
    output logic [IDX_W-1:0]    pal_rd_idx,
    input  logic [3*COMP_W-1:0] pal_rd_data,
    input  logic                pix_ready,
    output logic                pix_valid,
    output logic [3*COMP_W-1:0] pix_rgb,
    output logic                pix_eol,
    output logic                pix_eof,
    output logic                frame_full
);

    pix_tag_t iss;
    logic     adv, pipe_empty, start_ok, busy, blank_q;

    pal_scan_ctrl #(
        .W_W(WIDTH_W), .H_W(HEIGHT_W), .ADDR_W(ADDR_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cfg_width(cfg_width), .cfg_height(cfg_height),
        .adv(adv), .pipe_empty(pipe_empty), .start_ok(start_ok),
        .busy(busy), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .iss(iss)
    );

    pal_scan_pipe #(
        .IDX_W(IDX_W), .COMP_W(COMP_W)
    ) u_pipe (
        .clk(clk), .rst_n(rst_n), .iss(iss), .mem_rd_data(mem_rd_data),
        .blank_q(blank_q), .pix_ready(pix_ready), .pal_rd_data(pal_rd_data),
        .adv(adv), .pipe_empty(pipe_empty), .pal_rd_en(pal_rd_en),
        .pal_rd_idx(pal_rd_idx), .pix_valid(pix_valid), .pix_eol(pix_eol),
        .pix_eof(pix_eof), .pix_rgb(pix_rgb)
    );

    pal_scan_track #(
        .W_W(WIDTH_W), .H_W(HEIGHT_W)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .start_ok(start_ok),
        .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_blank(cfg_blank),
        .blank_q(blank_q), .frame_full(frame_full)
    );

    // R3: a blanked frame never touches the palette
    p_blank_no_pal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        blank_q |-> !pal_rd_en);

    // R9: a strobe during a frame leaves the redraw flag alone
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && busy) |=> $stable(frame_full));

endmodule

// File: tb/test_pal_scanout.sv
module test_pal_scanout;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [9:0]  cfg_width = '0;
    logic [9:0]  cfg_height = '0;
    logic        cfg_blank = 1'b0;
    logic        mem_rd_en;
    logic [19:0] mem_rd_addr;
    logic [7:0]  mem_rd_data = '0;
    logic        pal_rd_en;
    logic [7:0]  pal_rd_idx;
    logic [23:0] pal_rd_data = '0;
    logic        pix_ready = 1'b1;
    logic        pix_valid;
    logic [23:0] pix_rgb;
    logic        pix_eol;
    logic        pix_eof;
    logic        frame_full;

    always #2 clk = ~clk;

    pal_scanout i_pal_scanout (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_blank(cfg_blank),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .pal_rd_en(pal_rd_en), .pal_rd_idx(pal_rd_idx), .pal_rd_data(pal_rd_data),
        .pix_ready(pix_ready), .pix_valid(pix_valid), .pix_rgb(pix_rgb),
        .pix_eol(pix_eol), .pix_eof(pix_eof), .frame_full(frame_full)
    );

    int n_chk = 0, n_fail = 0;
    int mem_reads = 0, pal_reads = 0, valid_seen = 0;
    int exp_n = 0, cur_w = 0, cur_h = 0;
    bit cur_blank = 0;
    int rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit prev_stall = 0;
    logic [23:0] prev_rgb;
    logic prev_eol, prev_eof;
    bit seen_first = 0;
    int pw = 0, ph = 0;
    bit pb = 0;

    function automatic logic [7:0] vram_val(int a);
        return 8'(a * 29 + 7);
    endfunction

    function automatic logic [23:0] pal_val(logic [7:0] i);
        return {i ^ 8'hA5, 8'(i + 8'd17), ~i};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // synchronous video memory and palette models
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= vram_val(int'(mem_rd_addr[5:0]));
            mem_reads   <= mem_reads + 1;
        end
        if (pal_rd_en) begin
            pal_rd_data <= pal_val(pal_rd_idx);
            pal_reads   <= pal_reads + 1;
        end
    end

    // ready driver and pixel checker
    always @(negedge clk) begin
        if (prev_stall)
            chk(pix_valid && pix_rgb == prev_rgb && pix_eol == prev_eol && pix_eof == prev_eof,
                "R6 hold", {6'd0, pix_valid, pix_eol, pix_rgb}, {6'd0, 1'b1, prev_eol, prev_rgb});
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0:       pix_ready = 1'b1;
            1:       pix_ready = lfsr[0] | lfsr[3];
            default: pix_ready = lfsr[0] & lfsr[5];
        endcase
        if (pix_valid) valid_seen++;
        if (pix_valid && pix_ready) begin
            if (cur_w == 0 || cur_h == 0 || exp_n >= cur_w * cur_h) begin
                chk(1'b0, "R10 extra pixel", exp_n, cur_w * cur_h);
            end else begin
                // R1 R2 R3: colour of pixel n
                chk(pix_rgb == (cur_blank ? 24'h0 : pal_val(vram_val(exp_n))),
                    cur_blank ? "R3 black" : "R1 R2 colour", pix_rgb,
                    cur_blank ? 24'h0 : pal_val(vram_val(exp_n)));
                // R5: tags
                chk(pix_eol == ((exp_n % cur_w) == cur_w - 1), "R5 eol", pix_eol,
                    32'((exp_n % cur_w) == cur_w - 1));
                chk(pix_eof == (exp_n == cur_w * cur_h - 1), "R5 eof", pix_eof,
                    32'(exp_n == cur_w * cur_h - 1));
            end
            exp_n++;
        end
        prev_stall = pix_valid && !pix_ready;
        prev_rgb   = pix_rgb;
        prev_eol   = pix_eol;
        prev_eof   = pix_eof;
    end

    task automatic run_frame(input int w, input int h, input bit blank, input int mode, input bit mid);
        int r0, p0, guard;
        bit exp_full;
        exp_full = !seen_first || w != pw || h != ph || blank != pb;
        seen_first = 1; pw = w; ph = h; pb = blank;
        @(negedge clk);
        cur_w = w; cur_h = h; cur_blank = blank; exp_n = 0; rdy_mode = mode;
        r0 = mem_reads; p0 = pal_reads;
        cfg_width = 10'(w); cfg_height = 10'(h); cfg_blank = blank;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        if (mid) begin
            // R8 R9: new settings and a second strobe while the frame runs
            repeat (3) @(negedge clk);
            cfg_width = 10'(w + 3); cfg_height = 10'(h + 1); cfg_blank = !blank;
            frame_start = 1'b1;
            @(negedge clk);
            frame_start = 1'b0;
        end
        guard = 0;
        while (exp_n < w * h && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (4) @(negedge clk);
        chk(exp_n == w * h, "R10 pixel count", exp_n, w * h);
        chk(!pix_valid, "R10 quiet after frame", pix_valid, 0);
        chk(mem_reads - r0 == w * h, "R10 read count", mem_reads - r0, w * h);
        if (blank) chk(pal_reads == p0, "R3 no palette read", pal_reads - p0, 0);
        else       chk(pal_reads - p0 == w * h, "R1 palette reads", pal_reads - p0, w * h);
        chk(frame_full == exp_full, mid ? "R7 R9 full flag" : "R7 full flag", frame_full, exp_full);
    endtask

    task automatic zero_frame(input int w, input int h);
        int r0, v0;
        bit f0;
        @(negedge clk);
        cur_w = w; cur_h = h; exp_n = 0;
        r0 = mem_reads; v0 = valid_seen; f0 = frame_full;
        cfg_width = 10'(w); cfg_height = 10'(h); cfg_blank = 1'b1;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        repeat (10) @(negedge clk);
        chk(mem_reads == r0, "R4 no read", mem_reads - r0, 0);
        chk(valid_seen == v0, "R4 no pixel", valid_seen - v0, 0);
        chk(frame_full == f0, "R4 flag kept", frame_full, f0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!pix_valid, "R11 valid", pix_valid, 0);
        chk(!mem_rd_en, "R11 mem read", mem_rd_en, 0);
        chk(!pal_rd_en, "R11 pal read", pal_rd_en, 0);
        chk(frame_full == 1'b0, "R11 flag", frame_full, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pix_valid && !mem_rd_en && frame_full == 1'b0, "R11 after release", pix_valid, 0);

        run_frame(4, 3, 0, 1, 0);
        run_frame(4, 3, 0, 0, 0);
        run_frame(4, 3, 1, 1, 0);
        run_frame(4, 3, 1, 2, 0);
        run_frame(4, 3, 0, 2, 0);
        run_frame(5, 3, 0, 1, 0);
        zero_frame(0, 3);
        zero_frame(5, 0);
        run_frame(5, 3, 0, 0, 0);
        run_frame(6, 2, 0, 1, 1);
        run_frame(6, 2, 1, 2, 1);
        for (int h = 1; h <= 8; h++)
            for (int w = 1; w <= 8; w++)
                run_frame(w, h, ((w + h) % 5) == 0, (w + h) % 3, 0);
        run_frame(64, 1, 0, 1, 0);
        run_frame(1, 64, 0, 1, 0);
        run_frame(1, 1, 0, 2, 0);
        finish_run();
    end

endmodule